// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Coherent Byte Access

This block is one 16-bit channel of a timer, reached from an 8-bit register bus. A free-running 16-bit count is supplied from outside. The channel works in one of two modes. In capture mode it stores the count when a chosen edge appears on an input pin. In compare mode it signals an event and acts on an output pin when the count equals a stored value. Either event sets a sticky flag that software clears.

The bus is 8 bits wide, so the 16-bit channel value is read and written one byte at a time. A two-byte access must not see or load a torn value. A read of the high byte freezes capture until the low byte has been read. A write of the high byte suspends compare matching until the low byte has been written.

The register map has three addresses. The control register is at 0. The high byte of the value (bits 15..8) is at 1, and the low byte (bits 7..0) is at 2. The control byte is laid out as {flag[7], 0[6], mode[5:4], edge[3:2], action[1:0]}. Read data is registered and appears one cycle after the read strobe.

Top module: `tcc_channel`

## Requirements
- R1: After reset the flag, the output pin and every control field are 0, so a read of address 0 returns 0x00.
- R2: Address 1 holds value bits 15..8 and address 2 holds bits 7..0. Both can be read and written in either mode, and the read data is valid in the cycle after the read strobe.
- R3: With mode 00 (capture), a qualifying edge on the pin copies the counter into the value and sets the flag (control bit 7). The pin passes through a two-flop synchroniser before edge detection, and the new value is readable within four cycles of the pin change.
- R4: The edge field (control bits 3:2) selects which edges capture: 00 none, 01 rising only, 10 falling only, 11 both. An edge that is not selected changes neither the value nor the flag.
- R5: In capture mode, a read of address 1 blocks capture until address 2 is read. Edges that arrive while capture is blocked leave the value and the flag unchanged. The first selected edge after the low-byte read captures again.
- R6: With any nonzero mode (compare), the flag is set in a cycle where the counter equals the full 16-bit value.
- R7: On a compare match, the output pin follows the action field (control bits 1:0) in the next cycle: 00 keep, 01 toggle, 10 drive 0, 11 drive 1. The pin holds its level when there is no match.
- R8: In compare mode, a write to address 1 stops matching until address 2 is written.
- R9: A write of 0 to control bit 7 clears the flag only if the most recent access to address 0 before it was a read that saw the flag set. Otherwise the flag stays set. A new event in the same cycle keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address (0 control, 1 value high, 2 value low) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| counter | input | 16 | Free-running timer count |
| cap_pin | input | 1 | Asynchronous capture input |
| cmp_out | output | 1 | Compare output pin |
| chan_flag | output | 1 | Sticky channel event flag |

## Verification
A capture lock stuck set shows as a low byte that stops following later edges, and a flag that stays clear at the next control read. A lock that never sets lets an edge between the two byte reads change the low byte, which the bench reads back a few cycles later. A compare lock that is wrong shows on cmp_out one cycle after the counter passes the stored value. A wrong arm state shows on the control read that follows the clearing write.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] A_VHI = 2'd1;
  localparam logic [ADDR_W-1:0] A_VLO = 2'd2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic [1:0] mode;
    edge_sel_e  edge_sel;
    pin_act_e   act;
  } ctl_t;
endpackage

// File: rtl/tcc_edge_det.sv
module tcc_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic [1:0] sel_i,
  output logic hit_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], pin_i};
  end

  logic rise, fall;
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
  assign hit_o = (rise & sel_i[0]) | (fall & sel_i[1]);
endmodule

// File: rtl/tcc_value_reg.sv
module tcc_value_reg #(
  parameter int DATA_W = 8,
  localparam int VAL_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_mode_i,
  input  logic              cap_req_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic              rd_hi_i,
  input  logic              rd_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [VAL_W-1:0]  counter_i,
  output logic [VAL_W-1:0]  value_o,
  output logic              cap_evt_o,
  output logic              cmp_ok_o
);
  logic cap_lock, cmp_lock;

  assign cap_evt_o = cap_mode_i & cap_req_i & ~cap_lock;
  assign cmp_ok_o  = ~cmp_lock;

  always_ff @(posedge clk) begin
    if (cap_evt_o) value_o <= counter_i;
    if (wr_hi_i)   value_o[VAL_W-1:DATA_W] <= wdata_i;
    if (wr_lo_i)   value_o[DATA_W-1:0]     <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lock <= 1'b0;
      cmp_lock <= 1'b0;
    end else begin
      if (rd_lo_i)                 cap_lock <= 1'b0;
      else if (rd_hi_i && cap_mode_i) cap_lock <= 1'b1;
      if (wr_lo_i)                 cmp_lock <= 1'b0;
      else if (wr_hi_i && !cap_mode_i) cmp_lock <= 1'b1;
    end
  end

  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
    (cap_evt_o && !wr_hi_i && !wr_lo_i) |=> (value_o == $past(counter_i))); // R3
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (cap_lock && !wr_hi_i && !wr_lo_i) |=> $stable(value_o)); // R5
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             ok_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic [VAL_W-1:0] counter_i,
  input  tcc_pkg::pin_act_e act_i,
  output logic             match_o,
  output logic             pin_o
);
  import tcc_pkg::*;

  assign match_o = en_i & ok_i & (counter_i == value_i);

  always_ff @(posedge clk) begin
    if (rst) pin_o <= 1'b0;
    else if (match_o) begin
      case (act_i)
        ACT_TOGGLE: pin_o <= ~pin_o;
        ACT_CLEAR:  pin_o <= 1'b0;
        ACT_SET:    pin_o <= 1'b1;
        default:    pin_o <= pin_o;
      endcase
    end
  end

  AST_PIN_SET: assert property (@(posedge clk) disable iff (rst)
    (match_o && act_i == ACT_SET) |=> pin_o); // R7
  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !match_o |=> $stable(pin_o)); // R7
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int VAL_W = 2 * DATA_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [tcc_pkg::ADDR_W-1:0] bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [VAL_W-1:0]           counter,
  input  logic                       cap_pin,
  output logic                       cmp_out,
  output logic                       chan_flag
);
  import tcc_pkg::*;

  ctl_t ctl;
  logic clr_arm;
  logic [VAL_W-1:0] value;
  logic cap_req, cap_evt, cmp_ok, match;
  logic unused_wbits;

  logic wr_ctl, wr_hi, wr_lo, rd_ctl, rd_hi, rd_lo, cap_mode;
  assign wr_ctl   = bus_wr & (bus_addr == A_CTL);
  assign wr_hi    = bus_wr & (bus_addr == A_VHI);
  assign wr_lo    = bus_wr & (bus_addr == A_VLO);
  assign rd_ctl   = bus_rd & (bus_addr == A_CTL);
  assign rd_hi    = bus_rd & (bus_addr == A_VHI);
  assign rd_lo    = bus_rd & (bus_addr == A_VLO);
  assign cap_mode = (ctl.mode == 2'b00);
  assign unused_wbits = ^bus_wdata[DATA_W-1:6];

  tcc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin_i(cap_pin),
    .sel_i(ctl.edge_sel), .hit_o(cap_req)
  );

  tcc_value_reg #(.DATA_W(DATA_W)) u_value (
    .clk(clk), .rst(rst), .cap_mode_i(cap_mode), .cap_req_i(cap_req),
    .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .rd_hi_i(rd_hi), .rd_lo_i(rd_lo),
    .wdata_i(bus_wdata), .counter_i(counter), .value_o(value),
    .cap_evt_o(cap_evt), .cmp_ok_o(cmp_ok)
  );

  tcc_compare #(.VAL_W(VAL_W)) u_cmp (
    .clk(clk), .rst(rst), .en_i(~cap_mode), .ok_i(cmp_ok),
    .value_i(value), .counter_i(counter), .act_i(ctl.act),
    .match_o(match), .pin_o(cmp_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      chan_flag <= 1'b0;
      clr_arm   <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= ctl_t'(bus_wdata[5:0]);
      if (cap_evt || match)
        chan_flag <= 1'b1;
      else if (wr_ctl && !bus_wdata[7] && clr_arm)
        chan_flag <= 1'b0;
      if (rd_ctl)      clr_arm <= chan_flag;
      else if (wr_ctl) clr_arm <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTL:   bus_rdata <= {chan_flag, 1'b0, ctl};
        A_VHI:   bus_rdata <= value[VAL_W-1:DATA_W];
        A_VLO:   bus_rdata <= value[DATA_W-1:0];
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(chan_flag) |-> $past(cap_evt || match)); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(chan_flag) |-> $past(wr_ctl && !bus_wdata[7])); // R9
  AST_CMP_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    (!cmp_ok && !cap_mode) |=> $stable(cmp_out)); // R8
endmodule

// File: tb/tcc_channel_bench.sv
`timescale 1ns/1ps
module tcc_channel_bench;
  logic clk = 0;
  logic rst = 1;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [15:0] counter = 0;
  logic cap_pin = 0;
  logic cmp_out, chan_flag;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_pend = 0;

  always #2 clk = ~clk;

  tcc_channel u_tcc_channel (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .counter(counter),
    .cap_pin(cap_pin), .cmp_out(cmp_out), .chan_flag(chan_flag)
  );

  // monitor: pops expected read data the cycle after each strobe
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: read got %02h expected %02h", t, bus_rdata, e);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(logic [1:0] a, logic [7:0] e, string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic check_bit(string t, logic act, logic e);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic pin_to(logic v, logic [15:0] c);
    @(negedge clk);
    counter = c; cap_pin = v;
    tick(4);
  endtask

  task automatic cnt_pulse(logic [15:0] v);
    @(negedge clk);
    counter = v;
    @(negedge clk);
    counter = 16'hFFFF;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    tick(4);
    rst = 0;
    tick(1);
    check_bit("R1 flag", chan_flag, 1'b0);
    check_bit("R1 cmp_out", cmp_out, 1'b0);
    bus_read(2'd0, 8'h00, "R1 ctl");

    bus_write(2'd1, 8'hA5);
    bus_write(2'd2, 8'h3C);
    bus_read(2'd1, 8'hA5, "R2 high");
    bus_read(2'd2, 8'h3C, "R2 low");

    // rising-only capture
    bus_write(2'd0, 8'h04);
    pin_to(1'b1, 16'h1234);
    bus_read(2'd1, 8'h12, "R3 high");
    bus_read(2'd2, 8'h34, "R3 low");
    bus_read(2'd0, 8'h84, "R3 flag");
    bus_write(2'd0, 8'h04);
    bus_read(2'd0, 8'h04, "R9 armed clear");

    pin_to(1'b0, 16'h5678);
    bus_read(2'd0, 8'h04, "R4 falling ignored flag");
    bus_read(2'd2, 8'h34, "R4 falling ignored value");

    // falling-only
    bus_write(2'd0, 8'h08);
    pin_to(1'b1, 16'h5678);
    bus_read(2'd2, 8'h34, "R4 rising ignored");
    pin_to(1'b0, 16'h9ABC);
    bus_read(2'd1, 8'h9A, "R4 falling high");
    bus_read(2'd2, 8'hBC, "R4 falling low");
    bus_read(2'd0, 8'h88, "R4 falling flag");
    bus_write(2'd0, 8'h08);

    // both edges
    bus_write(2'd0, 8'h0C);
    pin_to(1'b1, 16'h1111);
    bus_read(2'd2, 8'h11, "R4 both rise");
    pin_to(1'b0, 16'h2222);
    bus_read(2'd2, 8'h22, "R4 both fall");
    bus_read(2'd0, 8'h8C, "R4 both flag");
    bus_write(2'd0, 8'h0C);

    // capture lock
    pin_to(1'b1, 16'h3333);
    bus_read(2'd1, 8'h33, "R5 high locks");
    bus_read(2'd0, 8'h8C, "R5 flag before");
    bus_write(2'd0, 8'h0C);
    pin_to(1'b0, 16'h4444);
    bus_read(2'd0, 8'h0C, "R5 blocked flag");
    bus_read(2'd2, 8'h33, "R5 blocked value");
    pin_to(1'b1, 16'h5555);
    bus_read(2'd2, 8'h55, "R5 resumed");
    bus_read(2'd0, 8'h8C, "R5 resumed flag");
    bus_write(2'd0, 8'h0C);

    // clear without arming
    pin_to(1'b0, 16'h6666);
    bus_write(2'd0, 8'h0C);
    bus_read(2'd0, 8'h8C, "R9 unarmed write keeps flag");
    bus_write(2'd0, 8'h0C);
    bus_read(2'd0, 8'h0C, "R9 armed write clears");

    // compare, toggle
    counter = 16'hFFFF;
    bus_write(2'd1, 8'h01);
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'h11);
    check_bit("R7 idle", cmp_out, 1'b0);
    cnt_pulse(16'h0100);
    check_bit("R7 toggle", cmp_out, 1'b1);
    bus_read(2'd0, 8'h91, "R6 match flag");
    bus_write(2'd0, 8'h12);
    cnt_pulse(16'h0100);
    check_bit("R7 clear", cmp_out, 1'b0);
    bus_write(2'd0, 8'h13);
    cnt_pulse(16'h0100);
    check_bit("R7 set", cmp_out, 1'b1);
    cnt_pulse(16'h0101);
    check_bit("R6 no match", cmp_out, 1'b1);
    bus_write(2'd0, 8'h10);
    cnt_pulse(16'h0100);
    check_bit("R7 keep", cmp_out, 1'b1);

    // compare holdoff
    bus_write(2'd0, 8'h11);
    bus_write(2'd1, 8'h02);
    cnt_pulse(16'h0200);
    check_bit("R8 held off", cmp_out, 1'b1);
    bus_write(2'd2, 8'h00);
    cnt_pulse(16'h0200);
    check_bit("R8 resumed", cmp_out, 1'b0);
    bus_read(2'd1, 8'h02, "R2 high in compare mode");

    tick(4);
    summary();
  end
endmodule